// File: doc/BRIEF.md
# Asynchronous Undo Log Engine

This block sits on the device side of a coherent memory link, in front of a persistent memory region. When the host asks for exclusive ownership of a cache line so that it can modify it, the engine grants the request in the same cycle. It then works in the background to preserve what the line held before. It reads the prior contents from persistent memory and writes an undo record to a circular log region. Each record holds the line address, the old data and the epoch tag that was current when the grant was given.

Each line is logged only once per epoch. A small associative set of lines already logged in the open epoch filters out repeat requests, and that set is emptied whenever the epoch input changes. If the set is full, new lines are still logged on every request, so a record may be duplicated but is never lost. Two monotonic offsets are exported. The write offset counts records handed to the log port. The durable offset counts records whose completion has returned, and it advances strictly in record order even when completions come back out of order. Recovery can therefore roll back every line whose record carries an epoch newer than the last committed one.

The log is a ring of a fixed number of slots. A request for a new line is held off when the ring has no free slot, counting either from the first record of the open epoch or from the oldest record that is not yet durable. It is also held off when the internal pending queue is full. A request that hits a line already logged is always granted.

Top module: `undo_log_engine`

## Requirements
- R1: After reset, wr_off and dur_off are zero, and rd_req_valid, lw_valid and own_grant are low while own_req is low.
- R2: own_grant is asserted only in a cycle where own_req is high. A request for a line already recorded in the current epoch is granted in that same cycle, whatever the state of the log or memory ports.
- R3: The first granted request for a line in an epoch produces exactly one undo record. Later requests for that line in the same epoch produce none, as long as the logged-line set had room when the line was first logged.
- R4: Each record presents, on lw_addr, lw_data and lw_epoch, the requested line address, the data memory returned for that address, and the value of epoch_in in the cycle the request was granted.
- R5: Records leave in grant order. Record n (counting from 0 since reset) is written with lw_slot equal to n modulo LOG_SLOTS. wr_off rises by exactly one for each lw_valid/lw_ready handshake.
- R6: After epoch_in changes, the first request for any line, including one logged in the previous epoch, produces a new record tagged with the new epoch.
- R7: dur_off rises by at most one per cycle. It moves past record n only after completions (lc_valid with lc_slot = n mod LOG_SLOTS) have arrived for every record up to and including n, whatever order the completions come in. It never exceeds wr_off.
- R8: A request for a new line is not granted while LOG_SLOTS records have been granted since the current epoch began, or while LOG_SLOTS granted records are not yet durable, or while the pending queue (PEND_DEPTH entries plus the one in flight) is full. It is granted once the epoch advances or space frees.
- R9: Once TAG_ENTRIES distinct lines are tracked in an epoch, every further request for an untracked line is granted when space allows and produces its own record, including repeated requests for the same untracked line.
- R10: Each record is preceded by exactly one memory read, whose rd_req_addr equals that record's line address. rd_req_valid and rd_req_addr are held steady until rd_req_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_req | input | 1 | Host asks for exclusive ownership of a line |
| own_addr | input | ADDR_W | Line address of the ownership request |
| own_grant | output | 1 | Ownership granted this cycle |
| epoch_in | input | EPOCH_W | Current epoch number; a change opens a new epoch |
| rd_req_valid | output | 1 | Persistent memory read request |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_req_addr | output | ADDR_W | Line address to read |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | LINE_W | Old line contents |
| lw_valid | output | 1 | Undo record ready for the log |
| lw_ready | input | 1 | Log accepts the record |
| lw_slot | output | log2(LOG_SLOTS) | Ring slot of the record |
| lw_addr | output | ADDR_W | Record line address |
| lw_data | output | LINE_W | Record old line data |
| lw_epoch | output | EPOCH_W | Record epoch tag |
| lc_valid | input | 1 | A log write became durable |
| lc_slot | input | log2(LOG_SLOTS) | Slot whose write completed |
| wr_off | output | OFF_W | Monotonic count of records written |
| dur_off | output | OFF_W | Monotonic count of records durable in order |

## Verification
The assertions assume that memory answers each accepted read exactly once before another is accepted. They also assume that each slot handed to the log port completes exactly once, and that epoch_in changes only when the engine is quiet: every record durable and nothing pending. The bench keeps to these rules. Its memory model holds one outstanding read and its log model completes slots drawn from a list of issued, unfinished offsets. It changes the epoch only after the write and durable offsets have met and no record is expected, except in the single case where a blocked request waits across a fully drained log.

// File: rtl/undo_log_pkg.sv
package undo_log_pkg;

    // Record builder progress: idle, issuing the read, waiting for data, writing the record.
    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_READ  = 2'd1,
        FS_WAIT  = 2'd2,
        FS_WRITE = 2'd3
    } fetch_state_e;

    // Outcome of an ownership lookup.
    typedef struct packed {
        logic hit;      // line already logged in the open epoch
        logic room;     // a new record can be reserved
        logic grant;    // request granted this cycle
        logic new_rec;  // a record is reserved for this request
    } own_decision_t;

    // True when a span between two monotonic offsets has reached the ring size.
    function automatic logic span_reached(input logic [63:0] span, input logic [63:0] limit);
        return span >= limit;
    endfunction

endpackage

// File: rtl/ulog_pend_fifo.sv
module ulog_pend_fifo #(
    parameter int WIDTH = 48,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    rd_ptr, wr_ptr;
    logic [CW-1:0]    cnt;

    assign empty    = (cnt == '0);
    assign full     = (cnt == FULLC);
    assign pop_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= (wr_ptr == LAST) ? '0 : wr_ptr + PW'(1);
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PW'(1);
            end
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    // R8
    fifo_push_room_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full);
    // R10
    fifo_pop_data_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);

endmodule

// File: rtl/ulog_tag_set.sv
module ulog_tag_set #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              ins,
    output logic              hit,
    output logic              full
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int CW = $clog2(ENTRIES + 1);
    localparam logic [CW-1:0] FULLC = CW'(ENTRIES);

    logic [ENTRIES-1:0] valid;
    logic [ADDR_W-1:0]  tag [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [CW-1:0]      cnt;
    logic [CW-1:0]      fill_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tag[g] == lk_addr);
    end

    assign hit      = !clear && (|match);
    assign full     = !clear && (cnt == FULLC);
    assign fill_idx = clear ? '0 : cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
            cnt   <= '0;
        end else begin
            if (clear) begin
                valid <= '0;
            end
            if (ins) begin
                valid[IW'(fill_idx)] <= 1'b1;
                tag[IW'(fill_idx)]   <= lk_addr;
            end
            cnt <= fill_idx + CW'(ins);
        end
    end

    // R9
    tag_count_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt <= FULLC);
    // R9
    tag_insert_room_chk: assert property (@(posedge clk) disable iff (rst) ins |-> !full);
    // R3
    tag_no_double_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(match));

endmodule

// File: rtl/ulog_fetch.sv
module ulog_fetch
    import undo_log_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LINE_W  = 512,
    parameter int EPOCH_W = 16,
    parameter int OFF_W   = 32,
    parameter int SLOT_W  = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               q_empty,
    input  logic [ADDR_W-1:0]  q_addr,
    input  logic [EPOCH_W-1:0] q_epoch,
    output logic               q_pop,
    output logic               rd_req_valid,
    input  logic               rd_req_ready,
    output logic [ADDR_W-1:0]  rd_req_addr,
    input  logic               rd_rsp_valid,
    input  logic [LINE_W-1:0]  rd_rsp_data,
    output logic               lw_valid,
    input  logic               lw_ready,
    output logic [SLOT_W-1:0]  lw_slot,
    output logic [ADDR_W-1:0]  lw_addr,
    output logic [LINE_W-1:0]  lw_data,
    output logic [EPOCH_W-1:0] lw_epoch,
    output logic [OFF_W-1:0]   wr_off
);
    fetch_state_e       state;
    logic [ADDR_W-1:0]  cur_addr;
    logic [EPOCH_W-1:0] cur_epoch;
    logic [LINE_W-1:0]  cur_data;
    logic [OFF_W-1:0]   off_q;

    assign q_pop        = (state == FS_IDLE) && !q_empty;
    assign rd_req_valid = (state == FS_READ);
    assign rd_req_addr  = cur_addr;
    assign lw_valid     = (state == FS_WRITE);
    assign lw_slot      = off_q[SLOT_W-1:0];
    assign lw_addr      = cur_addr;
    assign lw_data      = cur_data;
    assign lw_epoch     = cur_epoch;
    assign wr_off       = off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= FS_IDLE;
            cur_addr  <= '0;
            cur_epoch <= '0;
            cur_data  <= '0;
            off_q     <= '0;
        end else begin
            unique case (state)
                FS_IDLE: begin
                    if (!q_empty) begin
                        cur_addr  <= q_addr;
                        cur_epoch <= q_epoch;
                        state     <= FS_READ;
                    end
                end
                FS_READ: begin
                    if (rd_req_ready) state <= FS_WAIT;
                end
                FS_WAIT: begin
                    if (rd_rsp_valid) begin
                        cur_data <= rd_rsp_data;
                        state    <= FS_WRITE;
                    end
                end
                FS_WRITE: begin
                    if (lw_ready) begin
                        off_q <= off_q + OFF_W'(1);
                        state <= FS_IDLE;
                    end
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));
    // R4
    lw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        lw_valid && !lw_ready |=> lw_valid && $stable(lw_addr) && $stable(lw_data) && $stable(lw_epoch));
    // R5
    wr_step_chk: assert property (@(posedge clk) disable iff (rst)
        lw_valid && lw_ready |=> (wr_off - $past(wr_off)) == OFF_W'(1));
    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(lw_valid && lw_ready) |=> $stable(wr_off));

endmodule

// File: rtl/ulog_durable.sv
module ulog_durable #(
    parameter int OFF_W     = 32,
    parameter int LOG_SLOTS = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         lc_valid,
    input  logic [$clog2(LOG_SLOTS)-1:0] lc_slot,
    input  logic [OFF_W-1:0]             wr_off,
    output logic [OFF_W-1:0]             dur_off
);
    localparam int SLOT_W = $clog2(LOG_SLOTS);
    localparam logic [OFF_W-1:0] SLOTS_OFF = OFF_W'(LOG_SLOTS);

    logic [LOG_SLOTS-1:0] done;
    logic [OFF_W-1:0]     dur_q;
    logic [SLOT_W-1:0]    head;
    logic                 advance;

    assign head    = dur_q[SLOT_W-1:0];
    assign advance = done[head] && (dur_q != wr_off);
    assign dur_off = dur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= '0;
            dur_q <= '0;
        end else begin
            if (lc_valid) done[lc_slot] <= 1'b1;
            if (advance) begin
                done[head] <= 1'b0;
                dur_q      <= dur_q + OFF_W'(1);
            end
        end
    end

    // R7
    dur_step_chk: assert property (@(posedge clk) disable iff (rst)
        (dur_off == $past(dur_off)) || ((dur_off - $past(dur_off)) == OFF_W'(1)));
    // R7
    dur_not_ahead_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_off - dur_off) <= SLOTS_OFF);
    // R7
    cpl_once_chk: assert property (@(posedge clk) disable iff (rst)
        lc_valid |-> !done[lc_slot]);

endmodule

// File: rtl/undo_log_engine.sv
module undo_log_engine
    import undo_log_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LINE_W      = 512,
    parameter int EPOCH_W     = 16,
    parameter int OFF_W       = 32,
    parameter int LOG_SLOTS   = 64,
    parameter int TAG_ENTRIES = 16,
    parameter int PEND_DEPTH  = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         own_req,
    input  logic [ADDR_W-1:0]            own_addr,
    output logic                         own_grant,
    input  logic [EPOCH_W-1:0]           epoch_in,
    output logic                         rd_req_valid,
    input  logic                         rd_req_ready,
    output logic [ADDR_W-1:0]            rd_req_addr,
    input  logic                         rd_rsp_valid,
    input  logic [LINE_W-1:0]            rd_rsp_data,
    output logic                         lw_valid,
    input  logic                         lw_ready,
    output logic [$clog2(LOG_SLOTS)-1:0] lw_slot,
    output logic [ADDR_W-1:0]            lw_addr,
    output logic [LINE_W-1:0]            lw_data,
    output logic [EPOCH_W-1:0]           lw_epoch,
    input  logic                         lc_valid,
    input  logic [$clog2(LOG_SLOTS)-1:0] lc_slot,
    output logic [OFF_W-1:0]             wr_off,
    output logic [OFF_W-1:0]             dur_off
);
    localparam int SLOT_W = $clog2(LOG_SLOTS);
    localparam int QW     = ADDR_W + EPOCH_W;
    localparam logic [OFF_W-1:0] SLOTS_OFF = OFF_W'(LOG_SLOTS);

    logic [EPOCH_W-1:0] epoch_q;
    logic               epoch_chg;
    logic [OFF_W-1:0]   alloc_off;
    logic [OFF_W-1:0]   base_off;
    logic               tag_hit, tag_full;
    logic               q_full, q_empty, q_pop;
    logic [QW-1:0]      q_head;
    logic               epoch_room, durable_room;
    own_decision_t      dec;

    assign epoch_chg    = (epoch_in != epoch_q);
    assign epoch_room   = epoch_chg || !span_reached(64'(alloc_off - base_off), 64'(LOG_SLOTS));
    assign durable_room = !span_reached(64'(alloc_off - dur_off), 64'(LOG_SLOTS));

    always_comb begin
        dec.hit     = tag_hit;
        dec.room    = !q_full && epoch_room && durable_room;
        dec.grant   = own_req && (dec.hit || dec.room);
        dec.new_rec = own_req && !dec.hit && dec.room;
    end

    assign own_grant = dec.grant;

    always_ff @(posedge clk) begin
        if (rst) begin
            epoch_q   <= '0;
            alloc_off <= '0;
            base_off  <= '0;
        end else begin
            epoch_q   <= epoch_in;
            alloc_off <= alloc_off + OFF_W'(dec.new_rec);
            if (epoch_chg) base_off <= alloc_off;
        end
    end

    ulog_tag_set #(
        .ADDR_W  (ADDR_W),
        .ENTRIES (TAG_ENTRIES)
    ) u_tags (
        .clk     (clk),
        .rst     (rst),
        .clear   (epoch_chg),
        .lk_addr (own_addr),
        .ins     (dec.new_rec && !tag_full),
        .hit     (tag_hit),
        .full    (tag_full)
    );

    ulog_pend_fifo #(
        .WIDTH (QW),
        .DEPTH (PEND_DEPTH)
    ) u_pend (
        .clk       (clk),
        .rst       (rst),
        .push      (dec.new_rec),
        .push_data ({own_addr, epoch_in}),
        .pop       (q_pop),
        .pop_data  (q_head),
        .empty     (q_empty),
        .full      (q_full)
    );

    ulog_fetch #(
        .ADDR_W  (ADDR_W),
        .LINE_W  (LINE_W),
        .EPOCH_W (EPOCH_W),
        .OFF_W   (OFF_W),
        .SLOT_W  (SLOT_W)
    ) u_fetch (
        .clk          (clk),
        .rst          (rst),
        .q_empty      (q_empty),
        .q_addr       (q_head[QW-1:EPOCH_W]),
        .q_epoch      (q_head[EPOCH_W-1:0]),
        .q_pop        (q_pop),
        .rd_req_valid (rd_req_valid),
        .rd_req_ready (rd_req_ready),
        .rd_req_addr  (rd_req_addr),
        .rd_rsp_valid (rd_rsp_valid),
        .rd_rsp_data  (rd_rsp_data),
        .lw_valid     (lw_valid),
        .lw_ready     (lw_ready),
        .lw_slot      (lw_slot),
        .lw_addr      (lw_addr),
        .lw_data      (lw_data),
        .lw_epoch     (lw_epoch),
        .wr_off       (wr_off)
    );

    ulog_durable #(
        .OFF_W     (OFF_W),
        .LOG_SLOTS (LOG_SLOTS)
    ) u_dur (
        .clk      (clk),
        .rst      (rst),
        .lc_valid (lc_valid),
        .lc_slot  (lc_slot),
        .wr_off   (wr_off),
        .dur_off  (dur_off)
    );

    // R2
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst) own_grant |-> own_req);
    // R8
    epoch_span_chk: assert property (@(posedge clk) disable iff (rst) (alloc_off - base_off) <= SLOTS_OFF);
    // R8
    durable_span_chk: assert property (@(posedge clk) disable iff (rst) (alloc_off - dur_off) <= SLOTS_OFF);
    // R5
    alloc_leads_write_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_off - wr_off) <= OFF_W'(PEND_DEPTH + 1));

endmodule

// File: tb/undo_log_engine_tb.sv
`timescale 1ns/1ps
module undo_log_engine_tb;
    localparam int ADDR_W = 32, LINE_W = 512, EPOCH_W = 16, OFF_W = 32;
    localparam int LOG_SLOTS = 64, TAG_ENTRIES = 16, PEND_DEPTH = 4;
    localparam int SLOT_W = $clog2(LOG_SLOTS);
    localparam int CYCLE_LIMIT = 150000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic               rst = 1'b1;
    logic               own_req = 1'b0;
    logic [ADDR_W-1:0]  own_addr = '0;
    logic               own_grant;
    logic [EPOCH_W-1:0] epoch_in = '0;
    logic               rd_req_valid;
    logic               rd_req_ready = 1'b0;
    logic [ADDR_W-1:0]  rd_req_addr;
    logic               rd_rsp_valid = 1'b0;
    logic [LINE_W-1:0]  rd_rsp_data = '0;
    logic               lw_valid;
    logic               lw_ready = 1'b0;
    logic [SLOT_W-1:0]  lw_slot;
    logic [ADDR_W-1:0]  lw_addr;
    logic [LINE_W-1:0]  lw_data;
    logic [EPOCH_W-1:0] lw_epoch;
    logic               lc_valid = 1'b0;
    logic [SLOT_W-1:0]  lc_slot = '0;
    logic [OFF_W-1:0]   wr_off;
    logic [OFF_W-1:0]   dur_off;

    undo_log_engine #(
        .ADDR_W(ADDR_W), .LINE_W(LINE_W), .EPOCH_W(EPOCH_W), .OFF_W(OFF_W),
        .LOG_SLOTS(LOG_SLOTS), .TAG_ENTRIES(TAG_ENTRIES), .PEND_DEPTH(PEND_DEPTH)
    ) u_dut (
        .clk(clk), .rst(rst), .own_req(own_req), .own_addr(own_addr), .own_grant(own_grant),
        .epoch_in(epoch_in), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .lw_valid(lw_valid), .lw_ready(lw_ready), .lw_slot(lw_slot), .lw_addr(lw_addr),
        .lw_data(lw_data), .lw_epoch(lw_epoch), .lc_valid(lc_valid), .lc_slot(lc_slot),
        .wr_off(wr_off), .dur_off(dur_off)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit wd_fired = 0;

    // bench model state
    logic [ADDR_W-1:0]  tracked[$];
    logic [ADDR_W-1:0]  req_list[$];
    logic [ADDR_W-1:0]  exp_addr[$];
    logic [EPOCH_W-1:0] exp_ep[$];
    int                 out_q[$];
    bit                 fin [0:8191];
    int                 contig = 0;
    int                 rec_count = 0;
    int                 grants_seen = 0;
    int                 reads_seen = 0;
    bit                 active = 0, granted_prev = 0;
    bit                 hold_cpl = 0, lw_block = 0, ep_bump = 0;
    int                 cpl_pick = -1;
    bit                 rsp_pending = 0;
    int                 rsp_delay = 0;
    logic [ADDR_W-1:0]  rsp_addr = '0;

    function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
        logic [LINE_W-1:0] v;
        for (int i = 0; i < LINE_W / 32; i++) v[i*32 +: 32] = a * 32'h9E3779B1 + 32'(i);
        return v;
    endfunction

    function automatic bit in_set(input logic [ADDR_W-1:0] a);
        foreach (tracked[i]) if (tracked[i] == a) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (cyc > CYCLE_LIMIT && !wd_fired) begin
            wd_fired = 1;
            check(1'b0, "R5", "watchdog expired", 64'(cyc), 64'(CYCLE_LIMIT));
        end
        // ---- drive phase ----
        if (granted_prev) begin own_req = 1'b0; active = 0; granted_prev = 0; end
        if (!active && req_list.size() > 0 && $urandom_range(0, 3) != 0) begin
            own_addr = req_list.pop_front();
            own_req  = 1'b1;
            active   = 1;
        end
        if (ep_bump) begin
            epoch_in = epoch_in + EPOCH_W'(1);
            tracked.delete();
            ep_bump = 0;
        end
        lw_ready     = lw_block ? 1'b0 : ($urandom_range(0, 2) != 0);
        rd_req_ready = ($urandom_range(0, 2) != 0);
        rd_rsp_valid = 1'b0;
        if (rsp_pending) begin
            if (rsp_delay == 0) begin
                rd_rsp_valid = 1'b1;
                rd_rsp_data  = line_of(rsp_addr);
                rsp_pending  = 0;
            end else rsp_delay--;
        end
        lc_valid = 1'b0;
        if (cpl_pick >= 0) begin
            foreach (out_q[i]) if (out_q[i] == cpl_pick) begin out_q.delete(i); break; end
            lc_valid = 1'b1;
            lc_slot  = SLOT_W'(cpl_pick);
            fin[cpl_pick % 8192] = 1;
            cpl_pick = -1;
        end else if (!hold_cpl && out_q.size() > 0 && $urandom_range(0, 1) == 1) begin
            int idx;
            idx = $urandom_range(0, out_q.size() - 1);
            lc_valid = 1'b1;
            lc_slot  = SLOT_W'(out_q[idx]);
            fin[out_q[idx] % 8192] = 1;
            out_q.delete(idx);
        end
        while (fin[contig % 8192] && contig < rec_count) contig++;
        #1;
        // ---- observe phase ----
        if (own_req && !granted_prev) begin
            bit hit;
            hit = in_set(own_addr);
            if (hit) check(own_grant == 1'b1, "R2", "logged line granted at once", 64'(own_grant), 1);
            if (own_grant) begin
                grants_seen++;
                granted_prev = 1;
                if (!hit) begin
                    exp_addr.push_back(own_addr);
                    exp_ep.push_back(epoch_in);
                    if (tracked.size() < TAG_ENTRIES) tracked.push_back(own_addr);
                end
            end
        end
        if (rd_req_valid && rd_req_ready) begin
            reads_seen++;
            if (exp_addr.size() > 0)
                check(rd_req_addr == exp_addr[0], "R10", "read address", 64'(rd_req_addr), 64'(exp_addr[0]));
            else check(1'b0, "R10", "read with no record due", 64'(rd_req_addr), 0);
            rsp_pending = 1;
            rsp_delay   = $urandom_range(0, 2);
            rsp_addr    = rd_req_addr;
        end
        check(wr_off == OFF_W'(rec_count), "R5", "write offset", 64'(wr_off), 64'(rec_count));
        check(dur_off <= OFF_W'(contig), "R7", "durable offset bound", 64'(dur_off), 64'(contig));
        if (lw_valid && lw_ready) begin
            if (exp_addr.size() > 0) begin
                check(lw_addr == exp_addr[0], "R4", "record address", 64'(lw_addr), 64'(exp_addr[0]));
                check(lw_epoch == exp_ep[0], "R4", "record epoch", 64'(lw_epoch), 64'(exp_ep[0]));
                check(lw_data == line_of(lw_addr), "R4", "record old data", lw_data[63:0], line_of(lw_addr)>>0);
                void'(exp_addr.pop_front());
                void'(exp_ep.pop_front());
            end else check(1'b0, "R3", "unexpected record", 64'(lw_addr), 0);
            check(lw_slot == SLOT_W'(rec_count % LOG_SLOTS), "R5", "record slot", 64'(lw_slot), 64'(rec_count % LOG_SLOTS));
            fin[rec_count % 8192] = 0;
            out_q.push_back(rec_count);
            rec_count++;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n && !wd_fired; i++) step();
    endtask

    task automatic drain(input string req);
        int guard = 0;
        while (!wd_fired && guard < 5000 &&
               (req_list.size() > 0 || active || exp_addr.size() > 0 || rsp_pending ||
                (!hold_cpl && (out_q.size() > 0 || dur_off != OFF_W'(rec_count))))) begin
            step();
            guard++;
        end
        run(3);
        check(exp_addr.size() == 0, req, "records outstanding after drain", 64'(exp_addr.size()), 0);
    endtask

    task automatic bump_epoch();
        ep_bump = 1;
        step();
    endtask

    initial begin
        int base_rec, base_grants;
        // reset, R1
        run(3);
        check(wr_off == '0, "R1", "reset write offset", 64'(wr_off), 0);
        check(dur_off == '0, "R1", "reset durable offset", 64'(dur_off), 0);
        check(!rd_req_valid && !lw_valid, "R1", "reset ports idle", 64'({rd_req_valid, lw_valid}), 0);
        check(!own_grant, "R1", "reset no grant", 64'(own_grant), 0);
        @(negedge clk);
        rst = 1'b0;
        run(2);

        // R3: one record for repeated requests in one epoch
        bump_epoch();
        base_rec = rec_count;
        req_list.push_back(32'h100); req_list.push_back(32'h100); req_list.push_back(32'h100);
        drain("R3");
        check(rec_count - base_rec == 1, "R3", "records for repeated line", 64'(rec_count - base_rec), 1);

        // R6: same line logged again after epoch advance
        bump_epoch();
        base_rec = rec_count;
        req_list.push_back(32'h100);
        drain("R6");
        check(rec_count - base_rec == 1, "R6", "relog after epoch change", 64'(rec_count - base_rec), 1);

        // R7: out-of-order completions
        hold_cpl = 1;
        base_rec = rec_count;
        req_list.push_back(32'h201); req_list.push_back(32'h202); req_list.push_back(32'h203);
        drain("R7");
        cpl_pick = base_rec + 2; step();
        cpl_pick = base_rec + 1; step();
        run(4);
        check(dur_off == OFF_W'(base_rec), "R7", "durable held by gap", 64'(dur_off), 64'(base_rec));
        cpl_pick = base_rec; step();
        run(5);
        check(dur_off == OFF_W'(rec_count), "R7", "durable after gap filled", 64'(dur_off), 64'(rec_count));
        hold_cpl = 0;

        // R9: logged-line set overflow
        bump_epoch();
        base_rec = rec_count;
        for (int i = 0; i < TAG_ENTRIES; i++) req_list.push_back(32'h1000 + 32'(i));
        req_list.push_back(32'h1F00); req_list.push_back(32'h1F00);
        drain("R9");
        check(rec_count - base_rec == TAG_ENTRIES + 2, "R9", "records with full set",
              64'(rec_count - base_rec), 64'(TAG_ENTRIES + 2));
        base_rec = rec_count;
        req_list.push_back(32'h1000);
        drain("R3");
        check(rec_count - base_rec == 0, "R3", "tracked line not relogged", 64'(rec_count - base_rec), 0);

        // R8: pending queue full
        bump_epoch();
        lw_block = 1;
        base_grants = grants_seen;
        for (int i = 0; i < 8; i++) req_list.push_back(32'h3000 + 32'(i));
        run(40);
        check(grants_seen - base_grants == PEND_DEPTH + 1, "R8", "grants with log port stalled",
              64'(grants_seen - base_grants), 64'(PEND_DEPTH + 1));
        lw_block = 0;
        drain("R8");

        // R8: log ring full
        bump_epoch();
        hold_cpl = 1;
        base_rec = rec_count;
        for (int i = 0; i < LOG_SLOTS; i++) req_list.push_back(32'h5000 + 32'(i));
        drain("R8");
        check(rec_count - base_rec == LOG_SLOTS, "R8", "ring filled", 64'(rec_count - base_rec), 64'(LOG_SLOTS));
        req_list.push_back(32'h5000);
        drain("R2");
        base_grants = grants_seen;
        req_list.push_back(32'h6000);
        run(20);
        check(grants_seen == base_grants, "R8", "new line blocked on full ring", 64'(grants_seen - base_grants), 0);
        hold_cpl = 0;
        for (int g = 0; g < 2000 && dur_off != OFF_W'(rec_count) && !wd_fired; g++) step();
        run(5);
        check(grants_seen == base_grants, "R8", "blocked until epoch advances", 64'(grants_seen - base_grants), 0);
        base_rec = rec_count;
        bump_epoch();
        check(grants_seen == base_grants + 1, "R8", "granted on epoch advance", 64'(grants_seen - base_grants), 1);
        drain("R6");
        check(rec_count - base_rec == 1, "R6", "record after advance", 64'(rec_count - base_rec), 1);

        // random phases, fixed seed
        void'($urandom(32'd1234));
        for (int p = 0; p < 12 && !wd_fired; p++) begin
            bump_epoch();
            for (int i = 0; i < 40; i++) req_list.push_back(32'h8000 + 32'($urandom_range(0, 23)));
            drain("R4");
            check(dur_off == wr_off, "R7", "durable catches up", 64'(dur_off), 64'(wr_off));
        end
        check(reads_seen == rec_count, "R10", "one read per record", 64'(reads_seen), 64'(rec_count));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule